// File: doc/BRIEF.md
# APB Secondary Interrupt Aggregator

This block gathers a parameterised number of level-sensitive interrupt sources, from 2 to 64, and folds them into one level-high request line for a primary interrupt controller. Software reaches it over an APB slave port. The sources are split into two 32-bit banks. Sources 0 to 31 sit in the lower bank and sources 32 to 63 in the upper bank. Each bank has three registers: enable, mask and final status.

A source reaches the output only when three things hold: its input is high, its enable bit is 1 and its mask bit is 0. The storage for unimplemented sources is not built, so those bits read back as zero. Software can therefore learn the source count by writing all ones to the enable registers and reading them back. The source inputs pass through one register stage before the status is formed.

Top module: `apb_irq_aggregator`

## Requirements
- R1: Enable registers sit at offset 0x00 (sources 0..31) and 0x04 (sources 32..63). They are written when psel, penable and pwrite are all high, and they read back what was written.
- R2: Mask registers sit at offset 0x08 (sources 0..31) and 0x0C (sources 32..63). They are written and read back in the same way as the enable registers.
- R3: Final-status registers sit at offset 0x30 (sources 0..31) and 0x34 (sources 32..63). Each bit reads 1 exactly when the registered source is high, its enable bit is 1 and its mask bit is 0. Writes to these offsets change nothing.
- R4: Source n below 32 uses bit n of the lower-bank registers. Source n from 32 to 63 uses bit n-32 of the upper-bank registers.
- R5: Enable and mask bits at or above NUM_SRC do not exist and read 0. When NUM_SRC is 32 or less, the upper enable register always reads 0.
- R6: irq_out is high while any final-status bit is 1. It responds one clock after the source input changes.
- R7: After reset, every enable and mask bit is 0 and irq_out is low.
- R8: Reads of any other offset return 0. pready is always 1.
- R9: Sources are level-sensitive. When a source falls, its status bit and irq_out (if no other bit is set) clear one clock later, with no software action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer ready, tied high |
| src_in | input | NUM_SRC | Level interrupt sources |
| irq_out | output | 1 | Aggregated level-high request |

## Verification
The hardest state to reach is a source in the upper bank. With the default of 40 sources, it must pass both qualifiers while every other bit in both banks stays masked or disabled, so that the upper status register and the output can be seen alone. The stimulus first sets every bit in both banks. It then opens single mask bits one at a time and toggles individual sources, and each status register is read after every step. The output is also checked in the cycle just after a source changes, to pin down the one-clock latency.

// File: rtl/apb_irq_aggregator.sv
module apb_irq_aggregator #(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic [NUM_SRC-1:0] src_in,
  output logic              irq_out
);

  localparam logic [ADDR_W-1:0] OFF_EN_LO   = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFF_EN_HI   = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFF_MSK_LO  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFF_MSK_HI  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] OFF_STAT_LO = ADDR_W'(12'h030);
  localparam logic [ADDR_W-1:0] OFF_STAT_HI = ADDR_W'(12'h034);

  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [63:0]        en_w;
  logic [63:0]        mask_w;
  logic [63:0]        stat_w;
  logic               wr_go;

  assign wr_go  = psel & penable & pwrite;
  assign pready = 1'b1;

  generate
    for (genvar i = 0; i < 64; i++) begin : g_bit
      if (i < NUM_SRC) begin : g_impl
        assign en_w[i]   = en_q[i];
        assign mask_w[i] = mask_q[i];
        assign stat_w[i] = src_q[i] & en_q[i] & ~mask_q[i];
      end else begin : g_absent
        assign en_w[i]   = 1'b0;
        assign mask_w[i] = 1'b0;
        assign stat_w[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      en_q   <= '0;
      mask_q <= '0;
    end else begin
      src_q <= src_in;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (wr_go && paddr == ((i < 32) ? OFF_EN_LO : OFF_EN_HI))
          en_q[i] <= pwdata[i % 32];
        if (wr_go && paddr == ((i < 32) ? OFF_MSK_LO : OFF_MSK_HI))
          mask_q[i] <= pwdata[i % 32];
      end
    end
  end

  assign irq_out = |stat_w;

  always_comb begin
    case (paddr)
      OFF_EN_LO:   prdata = en_w[31:0];
      OFF_EN_HI:   prdata = en_w[63:32];
      OFF_MSK_LO:  prdata = mask_w[31:0];
      OFF_MSK_HI:  prdata = mask_w[63:32];
      OFF_STAT_LO: prdata = stat_w[31:0];
      OFF_STAT_HI: prdata = stat_w[63:32];
      default:     prdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/apb_irq_aggregator_chk.sv
module apb_irq_aggregator_chk #(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [ADDR_W-1:0]  paddr,
  input logic [31:0]        pwdata,
  input logic [31:0]        prdata,
  input logic               pready,
  input logic [NUM_SRC-1:0] src_in,
  input logic               irq_out
);

  function automatic logic [31:0] hi_impl();
    logic [31:0] m;
    m = '0;
    for (int i = 32; i < 64; i++) if (i < NUM_SRC) m[i-32] = 1'b1;
    return m;
  endfunction

  localparam logic [31:0] HI_IMPL = hi_impl();

  logic rd_now;
  logic mapped;
  assign rd_now = psel & ~pwrite;
  assign mapped = (paddr == ADDR_W'(12'h000)) || (paddr == ADDR_W'(12'h004)) ||
                  (paddr == ADDR_W'(12'h008)) || (paddr == ADDR_W'(12'h00C)) ||
                  (paddr == ADDR_W'(12'h030)) || (paddr == ADDR_W'(12'h034));

  a_r8_pready_high: assert property (@(posedge clk) disable iff (!rst_n)
    pready);

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && !mapped) |-> (prdata == 32'h0));

  a_r5_hi_enable_width: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && paddr == ADDR_W'(12'h004)) |-> ((prdata & ~HI_IMPL) == 32'h0));

  a_r9_quiet_sources: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_in) == '0) |-> !irq_out);

  a_r7_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq_out);

endmodule

bind apb_irq_aggregator apb_irq_aggregator_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/apb_irq_aggregator_tb_top.sv
module apb_irq_aggregator_tb_top;
  localparam int NUM = 40;
  localparam int AW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready;
  logic [NUM-1:0] src_in = '0;
  logic irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [63:0] m_en = '0, m_mask = '0, m_src = '0, impl = '0;

  always #5 clk = ~clk;

  apb_irq_aggregator #(.NUM_SRC(NUM), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .src_in(src_in), .irq_out(irq_out));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] stat_model();
    return m_src & m_en & ~m_mask & impl;
  endfunction

  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected read", 64'(prdata), 64'hDEAD);
      end else begin
        check(tag_q.pop_front(), 64'(prdata), 64'(exp_q.pop_front()));
        check("R8 pready", 64'(pready), 64'h1);
      end
    end
  end

  task automatic apb_write(logic [AW-1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    case (a)
      12'h000: m_en[31:0]    = d & impl[31:0];
      12'h004: m_en[63:32]   = d & impl[63:32];
      12'h008: m_mask[31:0]  = d & impl[31:0];
      12'h00C: m_mask[63:32] = d & impl[63:32];
      default: ;
    endcase
  endtask

  task automatic apb_read(logic [AW-1:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic read_status(string tag);
    logic [63:0] s;
    s = stat_model();
    apb_read(12'h030, s[31:0], tag);
    apb_read(12'h034, s[63:32], tag);
  endtask

  task automatic drive_src(logic [63:0] v, string tag);
    logic prev;
    prev = |stat_model();
    @(posedge clk); #1;
    src_in = v[NUM-1:0];
    m_src = v & impl;
    @(negedge clk);
    check({tag, " R6 before latency"}, 64'(irq_out), 64'(prev));
    @(negedge clk);
    check({tag, " R6 after one clock"}, 64'(irq_out), 64'(|stat_model()));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM; i++) impl[i] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 irq during reset", 64'(irq_out), 64'h0);
    #1 rst_n = 1'b1;

    apb_read(12'h000, 32'h0, "R7 enable lo after reset");
    apb_read(12'h004, 32'h0, "R7 enable hi after reset");
    apb_read(12'h008, 32'h0, "R7 mask lo after reset");
    apb_read(12'h00C, 32'h0, "R7 mask hi after reset");
    @(negedge clk);
    check("R7 irq after reset", 64'(irq_out), 64'h0);

    apb_write(12'h008, 32'hFFFF_FFFF);
    apb_write(12'h00C, 32'hFFFF_FFFF);
    apb_write(12'h000, 32'hFFFF_FFFF);
    apb_write(12'h004, 32'hFFFF_FFFF);
    apb_read(12'h000, 32'hFFFF_FFFF, "R1 enable lo readback");
    apb_read(12'h004, 32'h0000_00FF, "R5 enable hi only implemented bits");
    apb_read(12'h008, 32'hFFFF_FFFF, "R2 mask lo readback");
    apb_read(12'h00C, 32'h0000_00FF, "R5 mask hi only implemented bits");

    drive_src({64{1'b1}}, "R2 all masked");
    read_status("R2 masked status zero");

    apb_write(12'h008, 32'hFFFF_FFF7);
    @(negedge clk);
    check("R6 irq after unmask bit3", 64'(irq_out), 64'h1);
    read_status("R3 status lo bit3");

    drive_src(~64'h8, "R9 source3 falls");
    read_status("R9 status cleared");
    drive_src({64{1'b1}}, "R9 source3 rises");

    apb_write(12'h008, 32'hFFFF_FFFF);
    apb_write(12'h00C, 32'hFFFF_FFF7);
    read_status("R4 source35 in hi bank bit3");
    @(negedge clk);
    check("R4 irq from hi bank", 64'(irq_out), 64'h1);

    apb_write(12'h004, 32'h0);
    read_status("R1 hi enable cleared");
    @(negedge clk);
    check("R1 irq after disable", 64'(irq_out), 64'h0);
    apb_write(12'h004, 32'hFFFF_FFFF);

    apb_write(12'h030, 32'h0);
    apb_write(12'h034, 32'h0);
    read_status("R3 status writes ignored");
    apb_read(12'h000, 32'hFFFF_FFFF, "R3 enable lo untouched by status write");

    apb_write(12'h008, 32'h0);
    apb_write(12'h00C, 32'h0);
    drive_src(64'h0000_0081_0000_0001, "R4 sources 0 32 39");
    read_status("R4 multiple bank status");
    drive_src(64'h0, "R9 all sources low");
    read_status("R9 all clear");

    apb_write(12'h010, 32'hFFFF_FFFF);
    apb_read(12'h010, 32'h0, "R8 unmapped 0x10");
    apb_read(12'h038, 32'h0, "R8 unmapped 0x38");
    apb_read(12'h040, 32'h0, "R8 unmapped 0x40");

    repeat (2) @(negedge clk);
    check("R8 scoreboard drained", 64'(exp_q.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule